// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block produces the slot timing for one single-wire, open-drain bus from a system clock. The clock rate is set by a parameter that gives the number of cycles in one microsecond. The block serves one command at a time. The command is a bus reset with a presence check, a one-bit write or a one-bit read. The block can only pull the line low or let it go. An external pull-up brings the line high, and slaves answer by holding the line low inside slots that the master starts.

A controller above this block puts a command on `cmd_i` and raises `cmd_valid_i` while `busy_o` is low. It then waits for the one-cycle `done_o` strobe. After that strobe, `rd_bit_o` holds the result of a read and `presence_o` holds the result of a reset. The bus input goes through a two-flop synchronizer before the block samples it. Every slot ends with a short recovery time in which the line is released.

Top module: `owm_bit_engine`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no command given, `busy_o`, `done_o`, `bus_pull_o`, `rd_bit_o` and `presence_o` are all 0.
- R2: `bus_pull_o` (1 = pull the line low) is 1 only while `busy_o` is 1. The line is released in every cycle in which the block is idle.
- R3: A write command (code 2'b01) with `wr_bit_i`=1 pulls the line low for 6 µs. `busy_o` then stays high for 65 µs in total: a 60 µs slot and a 5 µs recovery.
- R4: A write command with `wr_bit_i`=0 pulls the line low for 60 µs. `busy_o` stays high for 65 µs in total.
- R5: A read command (code 2'b10) pulls the line low for 6 µs and samples the synchronized line 15 µs after the slot starts. At `done_o`, `rd_bit_o` becomes 0 if the line was low and 1 if it was high. The slot lasts 65 µs.
- R6: A reset command (code 2'b00) pulls the line low for 480 µs and keeps `busy_o` high for 960 µs in total.
- R7: For a reset, the line is sampled 70 µs after it is released. At `done_o`, `presence_o` becomes 1 if the line was low and 0 if it was high.
- R8: `done_o` is a single-cycle pulse. It is high in the first cycle in which `busy_o` is low again after a command.
- R9: A command presented while `busy_o` is high is ignored. The running slot keeps its timing.
- R10: Code 2'b11 is reserved and is ignored: `busy_o` stays low and the line stays released.
- R11: A command held valid during the `done_o` cycle is accepted at that clock edge. `busy_o` is high again in the next cycle.
- R12: `rd_bit_o` changes only at the end of a read. `presence_o` changes only at the end of a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | 00 reset, 01 write, 10 read, 11 reserved |
| wr_bit_i | input | 1 | Bit to write, used with code 01 |
| busy_o | output | 1 | A slot is in progress |
| done_o | output | 1 | One-cycle end-of-command strobe |
| rd_bit_o | output | 1 | Result of the last read |
| presence_o | output | 1 | Result of the last reset |
| bus_i | input | 1 | Line level, asynchronous |
| bus_pull_o | output | 1 | 1 = drive the open-drain line low |

## Verification
Two events can fall in the same cycle: the end of a slot, marked by the `done_o` strobe, and the acceptance of the next command. The bench holds `cmd_valid_i` high through a whole read slot and changes the command to a write 0 while the read is still running. That write must not disturb the read timing. It must be accepted exactly in the done cycle, so that `busy_o` is high again one cycle later. The bench then checks the read result that was latched and the 60 µs low time of the write that follows it.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OWM_RESET = 2'b00,
    OWM_WRITE = 2'b01,
    OWM_READ  = 2'b10,
    OWM_RSVD  = 2'b11
  } owm_cmd_e;
endpackage

// File: rtl/owm_sync2.sv
module owm_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/owm_us_timer.sv
module owm_us_timer #(
  parameter int CYC_PER_US = 200,
  parameter int MAX_US     = 960,
  parameter int US_W       = $clog2(MAX_US + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            run_i,
  output logic            tick_o,
  output logic [US_W-1:0] us_o
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;

  assign tick_o = run_i && (pre_q == PRE_LAST);
  assign us_o   = us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        pre_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_us_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    us_q <= US_W'(MAX_US));
endmodule

// File: rtl/owm_bit_engine.sv
module owm_bit_engine
  import owm_pkg::*;
#(
  parameter int CYC_PER_US   = 200,
  parameter int W1_LOW_US    = 6,
  parameter int W0_LOW_US    = 60,
  parameter int SLOT_US      = 60,
  parameter int RECOVER_US   = 5,
  parameter int RD_SAMPLE_US = 15,
  parameter int RST_LOW_US   = 480,
  parameter int PRES_WAIT_US = 70,
  parameter int RST_TOTAL_US = 960
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       wr_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_bit_o,
  output logic       presence_o,
  input  logic       bus_i,
  output logic       bus_pull_o
);
  localparam int US_W = $clog2(RST_TOTAL_US + 1);
  localparam logic [US_W-1:0] T_W1   = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] T_W0   = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] T_SLOT = US_W'(SLOT_US + RECOVER_US);
  localparam logic [US_W-1:0] T_RDS  = US_W'(RD_SAMPLE_US);
  localparam logic [US_W-1:0] T_RL   = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] T_PS   = US_W'(RST_LOW_US + PRES_WAIT_US);
  localparam logic [US_W-1:0] T_RT   = US_W'(RST_TOTAL_US);

  owm_cmd_e        cmd_q;
  logic            wbit_q, busy_q, done_q, samp_q, rd_q, pres_q;
  logic            bus_s, tick, accept, end_evt, samp_evt;
  logic [US_W-1:0] us, us_next, t_low, t_samp, t_end;

  owm_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(bus_i), .q_o(bus_s)
  );

  owm_us_timer #(.CYC_PER_US(CYC_PER_US), .MAX_US(RST_TOTAL_US), .US_W(US_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clear_i(accept), .run_i(busy_q),
    .tick_o(tick), .us_o(us)
  );

  always_comb begin
    unique case (cmd_q)
      OWM_RESET: begin t_low = T_RL; t_samp = T_PS;  t_end = T_RT;   end
      OWM_READ:  begin t_low = T_W1; t_samp = T_RDS; t_end = T_SLOT; end
      default:   begin t_low = wbit_q ? T_W1 : T_W0; t_samp = T_RDS; t_end = T_SLOT; end
    endcase
  end

  assign accept   = cmd_valid_i && !busy_q && (owm_cmd_e'(cmd_i) != OWM_RSVD);
  assign us_next  = us + 1'b1;
  assign end_evt  = busy_q && tick && (us_next == t_end);
  assign samp_evt = busy_q && tick && (us_next == t_samp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= OWM_WRITE;
      wbit_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      samp_q <= 1'b1;
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      done_q <= end_evt;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= owm_cmd_e'(cmd_i);
        wbit_q <= wr_bit_i;
      end else if (end_evt) begin
        busy_q <= 1'b0;
      end
      if (samp_evt) samp_q <= bus_s;
      if (end_evt && cmd_q == OWM_READ)  rd_q   <= samp_q;
      if (end_evt && cmd_q == OWM_RESET) pres_q <= !samp_q;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rd_bit_o   = rd_q;
  assign presence_o = pres_q;
  assign bus_pull_o = busy_q && (us < t_low);

  assert_pull_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_pull_o |-> busy_o);
  assert_done_at_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o || $past(busy_o)) && $past(busy_o));
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ignores_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !end_evt) |=> busy_q && $stable(cmd_q) && $stable(wbit_q));
  assert_reserved_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_i == 2'b11) |=> !busy_o);
  assert_results_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_bit_o) && $stable(presence_o));
endmodule

// File: tb/owm_bit_engine_tb.sv
module owm_bit_engine_tb;
  localparam int CPU = 4;
  localparam int MD_NONE = 0, MD_RD = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wr_bit = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic busy, done, rd_bit, presence, pull;
  logic sl_pull;
  wire  bus_line = !(pull || sl_pull);

  int total = 0, bad = 0;
  int sl_mode = MD_NONE;
  logic sl_bit = 1'b1, sl_present = 1'b1;
  logic prev_pull = 1'b0;
  int low_cnt = 0, rd_hold = 0, pres_wait = 0, pres_hold = 0;

  always #2.5 clk = !clk;

  owm_bit_engine #(.CYC_PER_US(CPU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wr_bit_i(wr_bit), .busy_o(busy), .done_o(done), .rd_bit_o(rd_bit),
    .presence_o(presence), .bus_i(bus_line), .bus_pull_o(pull)
  );

  // slave model
  assign sl_pull = (rd_hold > 0) || (pres_hold > 0);
  always @(posedge clk) begin
    prev_pull <= pull;
    low_cnt   <= pull ? low_cnt + 1 : 0;
    if (rd_hold > 0) rd_hold <= rd_hold - 1;
    if (pres_hold > 0) pres_hold <= pres_hold - 1;
    if (pres_wait > 0) begin
      pres_wait <= pres_wait - 1;
      if (pres_wait == 1) pres_hold <= 100 * CPU;
    end
    if (pull && !prev_pull && sl_mode == MD_RD && !sl_bit) rd_hold <= 30 * CPU;
    if (!pull && prev_pull && low_cnt >= 400 * CPU && sl_present) pres_wait <= 20 * CPU;
  end

  function automatic int exp_busy(logic [1:0] c);
    return (c == 2'b00) ? 960 * CPU : 65 * CPU;
  endfunction
  function automatic int exp_low(logic [1:0] c, logic wb);
    if (c == 2'b00) return 480 * CPU;
    if (c == 2'b01 && !wb) return 60 * CPU;
    return 6 * CPU;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int b, output int p);
    b = 0; p = 0;
    while (busy) begin
      b++;
      if (pull) p++;
      if (b == 10) sl_mode = MD_NONE;
      @(negedge clk);
    end
  endtask

  task automatic issue(logic [1:0] c, logic wb, string tag);
    int b, p;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_bit = wb;
    @(negedge clk);
    cmd_valid = 1'b0;
    measure(b, p);
    chk({tag, " busy length"}, b, exp_busy(c));
    chk({tag, " low length"}, p, exp_low(c, wb));
    chk("R8 done in busy fall cycle", int'(done), 1);
    @(negedge clk);
    chk("R8 done single cycle", int'(done), 0);
    chk("R2 released when idle", int'(pull), 0);
  endtask

  task automatic main();
    logic exp_rd, exp_pr;
    int b, p;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 pull in reset", int'(pull), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 pull", int'(pull), 0);
    chk("R1 rd_bit", int'(rd_bit), 0);
    chk("R1 presence", int'(presence), 0);

    // R10 reserved code
    cmd_valid = 1'b1; cmd = 2'b11;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) begin
      chk("R10 reserved no busy", int'(busy), 0);
      chk("R10 reserved no pull", int'(pull), 0);
      @(negedge clk);
    end

    sl_present = 1'b1;
    issue(2'b00, 1'b0, "R6 reset present");
    chk("R7 presence seen", int'(presence), 1);
    sl_present = 1'b0;
    issue(2'b00, 1'b0, "R6 reset absent");
    chk("R7 no presence", int'(presence), 0);
    sl_present = 1'b1;

    issue(2'b01, 1'b1, "R3 write one");
    issue(2'b01, 1'b0, "R4 write zero");
    sl_mode = MD_RD; sl_bit = 1'b0;
    issue(2'b10, 1'b0, "R5 read zero");
    chk("R5 read zero value", int'(rd_bit), 0);
    sl_mode = MD_RD; sl_bit = 1'b1;
    issue(2'b10, 1'b0, "R5 read one");
    chk("R5 read one value", int'(rd_bit), 1);
    issue(2'b01, 1'b0, "R12 write after read");
    chk("R12 rd_bit held", int'(rd_bit), 1);
    chk("R12 presence held", int'(presence), 0);

    // R9 + R11: command held through a read, changed mid-slot
    sl_mode = MD_RD; sl_bit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'b10; wr_bit = 1'b1;
    @(negedge clk);
    cmd = 2'b01; wr_bit = 1'b0;
    measure(b, p);
    chk("R9 read slot kept busy", b, 65 * CPU);
    chk("R9 read low kept", p, 6 * CPU);
    chk("R8 done at fall", int'(done), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 accepted in done cycle", int'(busy), 1);
    chk("R5 read latched", int'(rd_bit), 0);
    measure(b, p);
    chk("R11 write zero low", p, 60 * CPU);
    chk("R11 write zero busy", b, 65 * CPU);
    @(negedge clk);

    // constrained random
    exp_rd = rd_bit; exp_pr = presence;
    for (int i = 0; i < 40; i++) begin
      logic [1:0] c;
      logic wb, sb;
      c  = ($urandom % 8 == 0) ? 2'b00 : (($urandom % 2 == 0) ? 2'b01 : 2'b10);
      wb = 1'($urandom);
      sb = 1'($urandom);
      sl_present = 1'($urandom);
      if (c == 2'b10) begin sl_mode = MD_RD; sl_bit = sb; exp_rd = sb; end
      if (c == 2'b00) exp_pr = sl_present;
      issue(c, wb, "R3 R4 R5 R6 random slot");
      chk("R5 random rd_bit", int'(rd_bit), int'(exp_rd));
      chk("R7 random presence", int'(presence), int'(exp_pr));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      main();
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 actual=hang expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule